// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block keeps the working copy of a device's configuration in 128 byte-wide registers, reached through a single-request address/data port of the kind a serial-interface front end would drive. One register also holds the result flags of the programming sequence. A lock flag stored inside the bank itself decides, for each address, whether a write lands and whether a read returns real contents.

Every request is decoded against a permission map. The map has two states, chosen by the lock flag. When a write is refused, the target register stays unchanged. When a read is refused, the returned data is forced to zero. In both cases an access-error output pulses.

A neighbouring programming controller gets three things. It has a direct view of any register, with no protection applied. It can see the lock state. It has a load path into the status register.

Top module: `guarded_cfg_bank`

## Requirements
- R1: After a synchronous reset every register holds 0x00, the lock is clear, and `rsp_valid`, `rsp_rdata` and `acc_err` are 0.
- R2: A read request sampled at a rising edge yields `rsp_valid`=1 with the data in the following cycle. A permitted read returns the register value as it was at the sampling edge.
- R3: While unlocked, writes to 0x00–0x0F and 0x78–0x7F are accepted. The new value is visible from the next cycle on.
- R4: While unlocked, 0x10–0x1F and 0x77 can be read but not written.
- R5: While unlocked, addresses 0x20–0x76 can be neither read nor written.
- R6: The lock state is bit 6 of register 0x05. `lock_state` shows that bit, and it governs every request sampled after the write that set it.
- R7: While locked, only writes to 0x7B and 0x7C are accepted.
- R8: While locked, only 0x77–0x7F can be read. Any other read returns 0x00.
- R9: A refused write leaves every register unchanged. A refused read or write makes `acc_err` high for exactly the one cycle after the request. A permitted access leaves `acc_err` low.
- R10: Driving `stat_load` high at a rising edge stores `stat_value` into 0x77, whatever the lock state.
- R11: `peek_data` shows the register selected by `peek_addr` combinationally, whatever the lock state.
- R12: Once set, the lock stays set until reset, because 0x05 cannot be written while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 8 | Read data, 0x00 when the read is refused |
| acc_err | output | 1 | One-cycle pulse for a refused access |
| stat_load | input | 1 | Load `stat_value` into the status register |
| stat_value | input | 8 | Programming result flags |
| peek_addr | input | 7 | Controller view address |
| peek_data | output | 8 | Unprotected register contents at `peek_addr` |
| lock_state | output | 1 | Current lock flag |

## Verification
Read data, `rsp_valid` and `acc_err` are all registered, so each is due exactly one cycle after the edge that samples its request. The driver stamps every expected item with that cycle number. The monitor compares at the falling edge of that cycle, and in every cycle with no item due it checks that both strobes are low. Register contents and the lock flag are checked through `peek_data` and `lock_state` half a cycle after a write or status load, since they follow the register directly. Requests are issued back to back, so a lock change is also seen by the very next request.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

    localparam int CFG_AW = 7;
    localparam int CFG_DW = 8;

    // lock flag location
    localparam int LOCK_ADDR = 5;
    localparam int LOCK_BIT  = 6;

    // status register
    localparam int STATUS_ADDR = 'h77;

    // unlocked map
    localparam int OPEN_RW_LO_HI = 'h0F;
    localparam int OPEN_RO_HI    = 'h1F;
    localparam int TOP_LO        = 'h77;
    localparam int TOP_HI        = 'h7F;
    localparam int TOP_RW_LO     = 'h78;

    // locked map: the only writable pair
    localparam int KEEP_A = 'h7B;
    localparam int KEEP_B = 'h7C;

    typedef struct packed {
        logic rd;
        logic wr;
    } perm_t;

endpackage

// File: rtl/gcb_perm_map.sv
module gcb_perm_map
    import gcb_pkg::*;
#(
    parameter int ADDR_W = CFG_AW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              locked,
    output perm_t             perm
);

    localparam logic [ADDR_W-1:0] A_RW_HI  = ADDR_W'(OPEN_RW_LO_HI);
    localparam logic [ADDR_W-1:0] A_RO_HI  = ADDR_W'(OPEN_RO_HI);
    localparam logic [ADDR_W-1:0] A_TOP_LO = ADDR_W'(TOP_LO);
    localparam logic [ADDR_W-1:0] A_TOP_HI = ADDR_W'(TOP_HI);
    localparam logic [ADDR_W-1:0] A_TRW_LO = ADDR_W'(TOP_RW_LO);
    localparam logic [ADDR_W-1:0] A_KEEP_A = ADDR_W'(KEEP_A);
    localparam logic [ADDR_W-1:0] A_KEEP_B = ADDR_W'(KEEP_B);

    logic in_top;
    logic in_low_ro;
    logic in_low_rw;
    logic in_top_rw;

    always_comb begin
        in_top    = (addr >= A_TOP_LO) && (addr <= A_TOP_HI);
        in_low_ro = (addr <= A_RO_HI);
        in_low_rw = (addr <= A_RW_HI);
        in_top_rw = (addr >= A_TRW_LO) && (addr <= A_TOP_HI);
        if (locked) begin
            perm.rd = in_top;
            perm.wr = (addr == A_KEEP_A) || (addr == A_KEEP_B);
        end else begin
            perm.rd = in_low_ro || in_top;
            perm.wr = in_low_rw || in_top_rw;
        end
    end

endmodule

// File: rtl/gcb_store.sv
module gcb_store
    import gcb_pkg::*;
#(
    parameter int ADDR_W = CFG_AW,
    parameter int DATA_W = CFG_DW,
    parameter int STAT_A = STATUS_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_load,
    input  logic [DATA_W-1:0] stat_value,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [DATA_W-1:0] lock_word
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] S_ADDR = ADDR_W'(STAT_A);
    localparam logic [ADDR_W-1:0] L_ADDR = ADDR_W'(LOCK_ADDR);

    logic [DATA_W-1:0] regs_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
        end else begin
            if (wr_en) regs_q[wr_addr] <= wr_data;
            if (stat_load) regs_q[S_ADDR] <= stat_value;
        end
    end

    assign rd_data   = regs_q[rd_addr];
    assign peek_data = regs_q[peek_addr];
    assign lock_word = regs_q[L_ADDR];

    // a cell changes only when a write or status load targets it
    for (genvar g = 0; g < DEPTH; g++) begin : g_hold
        assert_cell_held_R9: assert property (@(posedge clk) disable iff (rst)
            (!(wr_en && wr_addr == ADDR_W'(g)) && !(stat_load && g == STAT_A))
            |=> $stable(regs_q[g]));
    end

endmodule

// File: rtl/gcb_resp.sv
module gcb_resp
    import gcb_pkg::*;
#(
    parameter int DATA_W = CFG_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  perm_t             perm,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              acc_err
);

    logic is_rd;
    logic denied;

    always_comb begin
        is_rd  = req_valid && !req_write;
        denied = req_valid && (req_write ? !perm.wr : !perm.rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            acc_err   <= 1'b0;
        end else begin
            rsp_valid <= is_rd;
            rsp_rdata <= (is_rd && perm.rd) ? rd_data : '0;
            acc_err   <= denied;
        end
    end

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);
    assert_blocked_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && acc_err) |-> (rsp_rdata == '0));
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> $past(req_valid));

endmodule

// File: rtl/guarded_cfg_bank.sv
module guarded_cfg_bank
    import gcb_pkg::*;
#(
    parameter int ADDR_W = CFG_AW,
    parameter int DATA_W = CFG_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              acc_err,
    input  logic              stat_load,
    input  logic [DATA_W-1:0] stat_value,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic              lock_state
);

    perm_t             perm;
    logic [DATA_W-1:0] lock_word;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;

    assign lock_state = lock_word[LOCK_BIT];
    assign wr_en      = req_valid && req_write && perm.wr;

    gcb_perm_map #(.ADDR_W(ADDR_W)) u_map (
        .addr   (req_addr),
        .locked (lock_state),
        .perm   (perm)
    );

    gcb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_A(STATUS_ADDR)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (req_addr),
        .wr_data    (req_wdata),
        .stat_load  (stat_load),
        .stat_value (stat_value),
        .rd_addr    (req_addr),
        .rd_data    (rd_data),
        .peek_addr  (peek_addr),
        .peek_data  (peek_data),
        .lock_word  (lock_word)
    );

    gcb_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .perm      (perm),
        .rd_data   (rd_data),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .acc_err   (acc_err)
    );

    assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        lock_state |=> lock_state);
    assert_locked_write_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && lock_state &&
         req_addr != ADDR_W'(KEEP_A) && req_addr != ADDR_W'(KEEP_B)) |=> acc_err);
    assert_gap_denied_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !lock_state && req_addr >= ADDR_W'('h20) &&
         req_addr <= ADDR_W'('h76)) |=> acc_err);

endmodule

// File: tb/guarded_cfg_bank_test.sv
`timescale 1ns/1ps
module guarded_cfg_bank_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       acc_err;
    logic       stat_load = 1'b0;
    logic [7:0] stat_value = '0;
    logic [6:0] peek_addr = '0;
    logic [7:0] peek_data;
    logic       lock_state;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] model [128];

    typedef struct {
        bit         is_rd;
        bit         err;
        logic [7:0] data;
        string      tag;
        int         due;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    guarded_cfg_bank uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .acc_err(acc_err), .stat_load(stat_load),
        .stat_value(stat_value), .peek_addr(peek_addr), .peek_data(peek_data),
        .lock_state(lock_state)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // permission model from the requirement ranges
    function automatic bit locked_m();
        return model[5][6];
    endfunction
    function automatic bit rd_ok(int a);
        if (locked_m()) return (a >= 'h77);
        return (a <= 'h1F) || (a >= 'h77);
    endfunction
    function automatic bit wr_ok(int a);
        if (locked_m()) return (a == 'h7B) || (a == 'h7C);
        return (a <= 'h0F) || (a >= 'h78);
    endfunction

    // driver: called at a falling edge, returns one cycle later
    task automatic op(bit wr, int a, logic [7:0] d, string tag);
        exp_t e;
        bit ok;
        ok = wr ? wr_ok(a) : rd_ok(a);
        e.is_rd = !wr;
        e.err   = !ok;
        e.data  = (!wr && ok) ? model[a] : 8'h00;
        e.tag   = tag;
        e.due   = cyc + 1;
        sb.push_back(e);
        if (wr && ok) model[a] = d;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a[6:0];
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load_status(logic [7:0] v);
        stat_load  = 1'b1;
        stat_value = v;
        @(negedge clk);
        stat_load = 1'b0;
        model['h77] = v;
    endtask

    task automatic peek(int a, string tag);
        peek_addr = a[6:0];
        #1;
        chk(tag, peek_data, model[a]);
    endtask

    // monitor: scoreboard compare in the cycle each response is due
    always @(negedge clk) begin
        if (!rst) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " rsp_valid"}, rsp_valid, e.is_rd);
                chk({e.tag, " acc_err"}, acc_err, e.err);
                if (e.is_rd) chk({e.tag, " rdata"}, rsp_rdata, e.data);
            end else begin
                chk("R9 idle acc_err", acc_err, 0);
                chk("R2 idle rsp_valid", rsp_valid, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_rdata", rsp_rdata, 0);
        chk("R1 acc_err", acc_err, 0);
        chk("R1 lock", lock_state, 0);
        peek('h00, "R1 peek 00");
        peek('h7F, "R1 peek 7F");
        @(negedge clk);

        // R3 unlocked writable spans, back to back
        op(1, 'h00, 8'hA5, "R3 wr 00");
        op(1, 'h0F, 8'h3C, "R3 wr 0F");
        op(1, 'h78, 8'h81, "R3 wr 78");
        op(1, 'h7F, 8'hFE, "R3 wr 7F");
        op(1, 'h7B, 8'h12, "R3 wr 7B");
        op(1, 'h05, 8'h3F, "R6 wr 05 bit6 clear");
        chk("R6 lock stays clear", lock_state, 0);
        // R2 read back
        op(0, 'h00, 0, "R2 rd 00");
        op(0, 'h0F, 0, "R2 rd 0F");
        op(0, 'h78, 0, "R2 rd 78");
        op(0, 'h7F, 0, "R2 rd 7F");
        peek('h0F, "R11 peek 0F");

        // R4 read-only spans
        load_status(8'h5A);
        peek('h77, "R10 peek status");
        op(1, 'h10, 8'hFF, "R4 wr 10 refused");
        op(1, 'h1F, 8'hFF, "R4 wr 1F refused");
        op(1, 'h77, 8'hFF, "R4 wr 77 refused");
        peek('h10, "R9 10 unchanged");
        peek('h77, "R9 77 unchanged");
        op(0, 'h1F, 0, "R4 rd 1F");
        op(0, 'h77, 0, "R4 rd 77");

        // R5 unlisted gap
        op(1, 'h20, 8'h77, "R5 wr 20");
        op(1, 'h76, 8'h77, "R5 wr 76");
        op(0, 'h50, 0, "R5 rd 50");
        op(0, 'h76, 0, "R5 rd 76");
        peek('h20, "R5 20 unchanged");
        peek('h76, "R5 76 unchanged");
        @(negedge clk);

        // R6 set lock, then R7/R8 immediately after
        op(1, 'h05, 8'h40, "R6 wr 05 lock");
        chk("R6 lock_state", lock_state, 1);
        op(1, 'h00, 8'h11, "R7 wr 00 refused");
        op(1, 'h78, 8'h22, "R7 wr 78 refused");
        op(1, 'h7B, 8'h9C, "R7 wr 7B");
        op(1, 'h7C, 8'hC9, "R7 wr 7C");
        op(1, 'h05, 8'h00, "R12 unlock refused");
        chk("R12 lock held", lock_state, 1);
        peek('h00, "R9 00 unchanged");
        peek('h78, "R9 78 unchanged");
        op(0, 'h00, 0, "R8 rd 00 blocked");
        op(0, 'h1F, 0, "R8 rd 1F blocked");
        op(0, 'h77, 0, "R8 rd 77");
        op(0, 'h7B, 0, "R8 rd 7B");
        op(0, 'h7C, 0, "R8 rd 7C");
        load_status(8'hC3);
        op(0, 'h77, 0, "R10 rd status locked");
        peek('h05, "R11 peek locked 05");
        peek('h00, "R11 peek locked 00");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule